// File: doc/BRIEF.md
# Compact 8-bit Multicycle Processor Core

This block is a small multicycle processor with an 8-bit datapath. It holds eight 8-bit general registers, a 3-bit condition register and a 256-byte memory that stores both program and stack. Each instruction is one opcode byte followed by zero, one or two operand bytes. The two most significant opcode bits give the operand count. The core reads the opcode and its operands one byte per cycle, then executes. The last general register is also the stack pointer, which grows downward. Subroutine calls and returns pass the return address through that stack.

Software fills the memory through a byte-wide load port while reset is held low. When reset is released, execution starts at address 0. A register value leaves the core through a print port, which carries a one-cycle valid strobe. A sticky halted output rises when the core stops.

Top module: `byte_stack_core`

## Requirements
- R1: While `rst_n` is low, each cycle with `ld_we` high writes `ld_data` to memory at `ld_addr`. Reset clears every register except register 7, which is set to 0xF4. Reset also clears the program counter and the condition register, and drives `halted` and `prn_valid` low.
- R2: An instruction is (opcode[7:6] + 1) bytes long, and every non-branching instruction advances the program counter by that length. An operand byte that names a register uses only its low 3 bits.
- R3: Opcode 0x82 (operands: register, immediate) writes the immediate byte into the register. Opcode 0x47 (operand: register) presents the register value on `prn_data` with `prn_valid` high for exactly one cycle.
- R4: Opcode 0xA2 (operands: rA, rB) writes the low 8 bits of rA*rB into rA.
- R5: Opcode 0x45 (push rA) first decrements register 7, then stores rA at memory[register 7]. Opcode 0x46 (pop rA) first loads rA from memory[register 7], then increments register 7.
- R6: Opcode 0x50 (call rA) decrements register 7 and stores the address of the following instruction (PC+2) at memory[register 7], then jumps to the value of rA. Opcode 0x11 (return) loads the PC from memory[register 7], then increments register 7.
- R7: Opcode 0x54 (jump rA) loads the PC from rA.
- R8: Opcode 0xA7 (compare rA, rB) sets the condition register to 3'b001 when rA = rB, 3'b010 when rA > rB and 3'b100 when rA < rB (unsigned). Opcode 0x55 jumps to rA when bit 0 is set. Opcode 0x56 jumps to rA when bit 0 is clear. A branch that is not taken advances the PC by 2.
- R9: Opcode 0x01 raises `halted`, and so does any opcode not listed here. Once raised, `halted` stays high until reset, no further instruction executes and no print occurs.
- R10: Register 7 and the PC wrap modulo 256, so a push with register 7 = 0x00 stores at address 0xFF.
- R11: With opcode 0x01 at address 0, `halted` is low after the first rising edge that follows reset release and high after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also enables the load port |
| ld_we | input | 1 | Memory load write enable (honoured only in reset) |
| ld_addr | input | 8 | Memory load address |
| ld_data | input | 8 | Memory load byte |
| prn_valid | output | 1 | One-cycle strobe marking a printed value |
| prn_data | output | 8 | Printed register value |
| halted | output | 1 | Sticky stop indication |

## Verification
The bench runs small programs and compares the printed sequence. It targets the following corner cases, each with the fault it would reveal:
- A branch that is taken and one that falls through under each compare outcome. A wrong flag encoding or a missing PC+2 fall-through sends the program to a planted halt, and the expected prints never appear.
- The condition register is zero straight out of reset. If it were not, a leading conditional branch would pick the wrong path.
- The stack pointer moves in a fixed order around the memory access, and it wraps from 0x00 to 0xFF. A design that gets the order or the wrap wrong returns the wrong popped value or leaves the wrong stack pointer.
- A call must push the right return address. Otherwise the return lands elsewhere.
- A product that overflows must keep only its low 8 bits.
- Register indexes must be masked to their low 3 bits. Otherwise an out-of-range operand writes the wrong register.
- An undefined opcode and the halt must both stop the core in the right cycle. A print that leaks out after the stop is caught.

// File: rtl/bsc_pkg.sv
// Shared definitions for the compact processor core: opcode values,
// controller states and condition-register codes. Assumes 8-bit opcodes.
package bsc_pkg;

    localparam logic [7:0] OP_HLT  = 8'h01;
    localparam logic [7:0] OP_LDI  = 8'h82;
    localparam logic [7:0] OP_PRN  = 8'h47;
    localparam logic [7:0] OP_MUL  = 8'hA2;
    localparam logic [7:0] OP_PUSH = 8'h45;
    localparam logic [7:0] OP_POP  = 8'h46;
    localparam logic [7:0] OP_CALL = 8'h50;
    localparam logic [7:0] OP_RET  = 8'h11;
    localparam logic [7:0] OP_JMP  = 8'h54;
    localparam logic [7:0] OP_CMP  = 8'hA7;
    localparam logic [7:0] OP_JEQ  = 8'h55;
    localparam logic [7:0] OP_JNE  = 8'h56;

    localparam logic [2:0] FLG_EQ = 3'b001;
    localparam logic [2:0] FLG_GT = 3'b010;
    localparam logic [2:0] FLG_LT = 3'b100;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPA,
        ST_OPB,
        ST_EXEC,
        ST_STK2,
        ST_HALT
    } state_t;

endpackage

// File: rtl/bsc_mem.sv
// Unified program/stack memory: one synchronous write port and one
// combinational read port. Contents are not reset; they are loaded by
// the owner before use.
module bsc_mem #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Present the addressed byte in the same cycle.
    assign rdata = cells[raddr];

endmodule

// File: rtl/bsc_regfile.sv
// General register file with two read ports, one write port and a
// dedicated view of the top register, which serves as stack pointer.
// Assumes NREG is a power of two.
module bsc_regfile #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NREG    = 8,
    parameter int unsigned SP_INIT = 'hF4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    output logic [DATA_W-1:0]       rdata_a,
    output logic [DATA_W-1:0]       rdata_b,
    output logic [DATA_W-1:0]       sp
);
    localparam int unsigned RIDX_W = $clog2(NREG);
    localparam int unsigned SP_IDX = NREG - 1;

    logic [DATA_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL =
            (i == SP_IDX) ? DATA_W'(SP_INIT) : '0;
        // Hold one register: reset value, else take a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= RST_VAL;
            end else if (we && (waddr == RIDX_W'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign sp      = regs[SP_IDX];

    AST_SP_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (sp == DATA_W'(SP_INIT))); // R1

endmodule

// File: rtl/bsc_alu.sv
// Combinational arithmetic: truncated product and unsigned three-way
// compare producing a one-hot condition code.
module bsc_alu #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] product,
    output logic [2:0]        cmp_flags
);
    import bsc_pkg::*;

    // Product keeps only the low DATA_W bits by context width.
    assign product = a * b;

    // Encode the unsigned ordering of a against b.
    always_comb begin
        if (a == b) begin
            cmp_flags = FLG_EQ;
        end else if (a > b) begin
            cmp_flags = FLG_GT;
        end else begin
            cmp_flags = FLG_LT;
        end
    end

endmodule

// File: rtl/byte_stack_core.sv
// Multicycle 8-bit processor core. Fetches the opcode and up to two
// operand bytes one per cycle, executes, and uses a second cycle for
// stack operations so the register file needs a single write port.
// Assumes DATA_W = 8 (addresses are register-sized) and NREG a power of two.
module byte_stack_core #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NREG    = 8,
    parameter int unsigned SP_INIT = 'hF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [DATA_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              prn_valid,
    output logic [DATA_W-1:0] prn_data,
    output logic              halted
);
    import bsc_pkg::*;

    localparam int unsigned ADDR_W = DATA_W;
    localparam int unsigned RIDX_W = $clog2(NREG);
    localparam logic [RIDX_W-1:0] SP_IDX = RIDX_W'(NREG - 1);

    state_t            state;
    logic [DATA_W-1:0] pc;
    logic [7:0]        ir;
    logic [RIDX_W-1:0] opa_idx;
    logic [DATA_W-1:0] opb;
    logic [2:0]        flags;
    logic              halted_q;
    logic              prn_valid_q;
    logic [DATA_W-1:0] prn_data_q;

    logic [ADDR_W-1:0] mem_raddr;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;

    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] sp;

    logic [DATA_W-1:0] product;
    logic [2:0]        cmp_flags;
    logic [DATA_W-1:0] pc_step;
    logic [DATA_W-1:0] pc_two;

    assign pc_step = pc + DATA_W'(ir[7:6]) + DATA_W'(1);
    assign pc_two  = pc + DATA_W'(2);

    bsc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    bsc_regfile #(.DATA_W(DATA_W), .NREG(NREG), .SP_INIT(SP_INIT)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (opa_idx),
        .raddr_b (opb[RIDX_W-1:0]),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .sp      (sp)
    );

    bsc_alu #(.DATA_W(DATA_W)) u_alu (
        .a         (rd_a),
        .b         (rd_b),
        .product   (product),
        .cmp_flags (cmp_flags)
    );

    // Select the memory read address for the current phase.
    always_comb begin
        case (state)
            ST_FETCH: mem_raddr = pc;
            ST_OPA:   mem_raddr = pc + DATA_W'(1);
            ST_OPB:   mem_raddr = pc + DATA_W'(2);
            default:  mem_raddr = sp;
        endcase
    end

    // Memory writes: the load port during reset, stack stores otherwise.
    always_comb begin
        if (!rst_n) begin
            mem_we    = ld_we;
            mem_waddr = ld_addr;
            mem_wdata = ld_data;
        end else begin
            mem_we    = (state == ST_STK2) && ((ir == OP_PUSH) || (ir == OP_CALL));
            mem_waddr = sp;
            mem_wdata = (ir == OP_CALL) ? pc_two : rd_a;
        end
    end

    // Register file write requests for the execute and stack phases.
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = opa_idx;
        rf_wdata = opb;
        if (state == ST_EXEC) begin
            case (ir)
                OP_LDI: rf_we = 1'b1;
                OP_MUL: begin
                    rf_we    = 1'b1;
                    rf_wdata = product;
                end
                OP_POP: begin
                    rf_we    = 1'b1;
                    rf_wdata = mem_rdata;
                end
                OP_PUSH, OP_CALL: begin
                    rf_we    = 1'b1;
                    rf_waddr = SP_IDX;
                    rf_wdata = sp - DATA_W'(1);
                end
                default: rf_we = 1'b0;
            endcase
        end else if (state == ST_STK2 && (ir == OP_POP || ir == OP_RET)) begin
            rf_we    = 1'b1;
            rf_waddr = SP_IDX;
            rf_wdata = sp + DATA_W'(1);
        end
    end

    // Sequencer: fetch, operand reads, execute, stack completion, halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_FETCH;
            pc          <= '0;
            ir          <= '0;
            opa_idx     <= '0;
            opb         <= '0;
            flags       <= '0;
            halted_q    <= 1'b0;
            prn_valid_q <= 1'b0;
            prn_data_q  <= '0;
        end else begin
            prn_valid_q <= 1'b0;
            case (state)
                ST_FETCH: begin
                    ir    <= mem_rdata[7:0];
                    state <= (mem_rdata[7:6] == 2'b00) ? ST_EXEC : ST_OPA;
                end
                ST_OPA: begin
                    opa_idx <= mem_rdata[RIDX_W-1:0];
                    state   <= ir[7] ? ST_OPB : ST_EXEC;
                end
                ST_OPB: begin
                    opb   <= mem_rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    case (ir)
                        OP_LDI, OP_MUL: pc <= pc_step;
                        OP_PRN: begin
                            prn_valid_q <= 1'b1;
                            prn_data_q  <= rd_a;
                            pc          <= pc_step;
                        end
                        OP_CMP: begin
                            flags <= cmp_flags;
                            pc    <= pc_step;
                        end
                        OP_PUSH, OP_POP, OP_CALL: state <= ST_STK2;
                        OP_RET: begin
                            pc    <= mem_rdata;
                            state <= ST_STK2;
                        end
                        OP_JMP: pc <= rd_a;
                        OP_JEQ: pc <= flags[0] ? rd_a : pc_two;
                        OP_JNE: pc <= flags[0] ? pc_two : rd_a;
                        default: begin
                            halted_q <= 1'b1;
                            state    <= ST_HALT;
                        end
                    endcase
                end
                ST_STK2: begin
                    state <= ST_FETCH;
                    case (ir)
                        OP_PUSH, OP_POP: pc <= pc_step;
                        OP_CALL:         pc <= rd_a;
                        default:         pc <= pc;
                    endcase
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    assign prn_valid = prn_valid_q;
    assign prn_data  = prn_data_q;
    assign halted    = halted_q;

    AST_PRN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prn_valid_q |=> !prn_valid_q); // R3
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> halted_q); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |-> !prn_valid_q); // R9
    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags)); // R8
    AST_LDI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir == OP_LDI) |=> (pc == DATA_W'($past(pc) + 3))); // R2
    AST_PUSH_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && (ir == OP_PUSH || ir == OP_CALL))
        |=> (sp == DATA_W'($past(sp) - 1))); // R5
    AST_POP_SP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STK2 && (ir == OP_POP || ir == OP_RET))
        |=> (sp == DATA_W'($past(sp) + 1))); // R6

endmodule

// File: tb/test_byte_stack_core.sv
`timescale 1ns/1ps
// Directed bench: each task loads a program, runs it and checks the
// printed values and the halt behaviour at the ports.
module test_byte_stack_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       prn_valid;
    logic [7:0] prn_data;
    logic       halted;

    int n_checks = 0;
    int n_err = 0;

    logic [7:0] prog [256];
    int         plen = 0;
    logic [7:0] got [64];
    int         ngot = 0;

    always #2.5 clk = ~clk;

    byte_stack_core i_byte_stack_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .prn_valid (prn_valid),
        .prn_data  (prn_data),
        .halted    (halted)
    );

    // Record every print strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n && prn_valid) begin
            if (ngot < 64) got[ngot] = prn_data;
            ngot++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        plen = 0;
    endtask

    task automatic b(input logic [7:0] v);
        prog[plen] = v;
        plen++;
    endtask

    // Hold reset, stream the whole image through the load port.
    task automatic load_mem();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            ld_we   = 1'b1;
            ld_addr = 8'(i);
            ld_data = prog[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
        ngot  = 0;
        check(!halted && !prn_valid, "R1", "outputs low in reset",
              int'({halted, prn_valid}), 0);
    endtask

    task automatic run_prog(input string req, input int exp[$]);
        int cyc = 0;
        load_mem();
        rst_n = 1'b1;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (4) @(negedge clk);
        check(halted, req, "halted at program end", int'(halted), 1);
        check(ngot == exp.size(), req, "print count", ngot, exp.size());
        foreach (exp[k]) begin
            if (k < ngot && k < 64)
                check(int'(got[k]) == exp[k], req, $sformatf("print %0d", k),
                      int'(got[k]), exp[k]);
        end
    endtask

    // R11 R9: halt timing at address 0 and stickiness.
    task automatic t_halt_timing();
        clear_prog();
        b(8'h01);
        load_mem();
        rst_n = 1'b1;
        @(negedge clk);
        check(!halted, "R11", "halted after first edge", int'(halted), 0);
        @(negedge clk);
        check(halted, "R11", "halted after second edge", int'(halted), 1);
        repeat (20) @(negedge clk);
        check(halted, "R9", "halted stays high", int'(halted), 1);
        check(ngot == 0, "R9", "no print while halted", ngot, 0);
    endtask

    // R3 R2: immediate load, print, masked register index.
    task automatic t_ldi_prn();
        clear_prog();
        b(8'h82); b(8'h00); b(8'h08);   // r0 = 8
        b(8'h47); b(8'h00);             // print r0
        b(8'h82); b(8'h0B); b(8'h2A);   // index 0x0B -> r3 = 42
        b(8'h47); b(8'h03);             // print r3
        b(8'h01);
        run_prog("R3", '{8, 42});
    endtask

    // R4: product and truncated product.
    task automatic t_mul();
        clear_prog();
        b(8'h82); b(8'h00); b(8'h08);
        b(8'h82); b(8'h01); b(8'h09);
        b(8'hA2); b(8'h00); b(8'h01);   // r0 = 72
        b(8'h47); b(8'h00);
        b(8'h82); b(8'h02); b(8'd20);
        b(8'h82); b(8'h03); b(8'd13);
        b(8'hA2); b(8'h02); b(8'h03);   // 260 -> 4
        b(8'h47); b(8'h02);
        b(8'h01);
        run_prog("R4", '{72, 4});
    endtask

    // R5 R1: stack order and initial stack pointer.
    task automatic t_stack();
        clear_prog();
        b(8'h47); b(8'h07);             // print sp = 0xF4
        b(8'h82); b(8'h00); b(8'h11);
        b(8'h82); b(8'h01); b(8'h22);
        b(8'h45); b(8'h00);             // push r0
        b(8'h45); b(8'h01);             // push r1
        b(8'h47); b(8'h07);             // 0xF2
        b(8'h46); b(8'h02);             // pop r2 = 0x22
        b(8'h46); b(8'h03);             // pop r3 = 0x11
        b(8'h47); b(8'h02);
        b(8'h47); b(8'h03);
        b(8'h47); b(8'h07);             // back to 0xF4
        b(8'h01);
        run_prog("R5", '{'hF4, 'hF2, 'h22, 'h11, 'hF4});
    endtask

    // R6: call to a subroutine and return.
    task automatic t_call();
        clear_prog();
        b(8'h82); b(8'h01); b(8'h08);   // 0: r1 = 8
        b(8'h50); b(8'h01);             // 3: call r1
        b(8'h47); b(8'h00);             // 5: print r0
        b(8'h01);                       // 7: halt
        b(8'h82); b(8'h00); b(8'h05);   // 8: r0 = 5
        b(8'h47); b(8'h07);             // 11: print sp = 0xF3
        b(8'h46); b(8'h04);             // 13: pop r4 = return address 5
        b(8'h45); b(8'h04);             // 15: push r4 back
        b(8'h47); b(8'h04);             // 17: print 5
        b(8'h11);                       // 19: return
        run_prog("R6", '{'hF3, 5, 5});
    endtask

    // R7 R8: compare outcomes, taken and fall-through branches, jump.
    task automatic t_branch();
        clear_prog();
        b(8'h82); b(8'h00); b(8'd10);   // 0
        b(8'h82); b(8'h01); b(8'd20);   // 3
        b(8'h82); b(8'h02); b(8'd25);   // 6: r2 = 25
        b(8'hA7); b(8'h00); b(8'h01);   // 9: less
        b(8'h55); b(8'h02);             // 12: not taken
        b(8'h82); b(8'h03); b(8'd1);    // 14
        b(8'h47); b(8'h03);             // 17: print 1
        b(8'hA7); b(8'h00); b(8'h00);   // 19: equal
        b(8'h55); b(8'h02);             // 22: taken to 25
        b(8'h01);                       // 24: trap
        b(8'h82); b(8'h03); b(8'd4);    // 25
        b(8'h47); b(8'h03);             // 28: print 4
        b(8'h56); b(8'h02);             // 30: not taken
        b(8'h82); b(8'h02); b(8'd41);   // 32: r2 = 41
        b(8'hA7); b(8'h01); b(8'h00);   // 35: greater
        b(8'h56); b(8'h02);             // 38: taken to 41
        b(8'h01);                       // 40: trap
        b(8'h47); b(8'h01);             // 41: print 20
        b(8'h82); b(8'h04); b(8'd49);   // 43: r4 = 49
        b(8'h54); b(8'h04);             // 46: jump
        b(8'h01);                       // 48: trap
        b(8'h47); b(8'h00);             // 49: print 10
        b(8'h01);                       // 51
        run_prog("R8", '{1, 4, 20, 10});
    endtask

    // R8: condition register is clear after reset.
    task automatic t_flags_reset();
        clear_prog();
        b(8'h82); b(8'h00); b(8'd11);   // 0
        b(8'h82); b(8'h01); b(8'd14);   // 3
        b(8'h55); b(8'h01);             // 6: bit0 clear -> fall through
        b(8'h56); b(8'h00);             // 8: bit0 clear -> taken to 11
        b(8'h01);                       // 10: trap
        b(8'h47); b(8'h00);             // 11: print 11
        b(8'h01);                       // 13
        b(8'h47); b(8'h01);             // 14: wrong path print 14
        b(8'h01);
        run_prog("R8", '{11});
    endtask

    // R10: stack pointer wraps below zero and back.
    task automatic t_wrap();
        clear_prog();
        b(8'h82); b(8'h07); b(8'h00);   // sp = 0
        b(8'h82); b(8'h00); b(8'h5A);
        b(8'h45); b(8'h00);             // push -> sp 0xFF
        b(8'h47); b(8'h07);
        b(8'h46); b(8'h01);             // pop r1
        b(8'h47); b(8'h01);
        b(8'h47); b(8'h07);
        b(8'h01);
        run_prog("R10", '{'hFF, 'h5A, 0});
    endtask

    // R9: undefined opcodes stop the core.
    task automatic t_undef();
        clear_prog();
        b(8'h82); b(8'h00); b(8'h03);
        b(8'hFF); b(8'h00); b(8'h00);   // undefined, three bytes long
        b(8'h47); b(8'h00);
        b(8'h01);
        run_prog("R9", '{});
        clear_prog();
        b(8'h47); b(8'h00);             // print 0
        b(8'h00);                       // undefined, one byte long
        b(8'h47); b(8'h00);
        b(8'h01);
        run_prog("R9", '{0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        t_halt_timing();
        t_ldi_prn();
        t_mul();
        t_stack();
        t_call();
        t_branch();
        t_flags_reset();
        t_wrap();
        t_undef();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule